// File: doc/BRIEF.md
# E1 Spare-Bit Transmit Inserter

This block rewrites the national spare bits of outgoing E1 timeslot-0 bytes. An E1 multiframe has sixteen frames. The even frames carry the frame alignment signal. The odd frames carry five spare bit positions, named Sa4 to Sa8. For each odd frame, the block replaces any subset of those five positions with values from one of two sources:

- a per-multiframe register bank holding one bit per odd frame for each position, or
- a serial bit stream pulled one bit at a time from an external HDLC or transparent source.

A 5-bit select mask chooses which positions are overwritten. All other bits pass through unchanged.

Configuration is written through a small register port into a shadow copy. The shadow copy is transferred into the working copy when the timeslot-0 byte of frame 0 is accepted. A reconfiguration therefore never splits a multiframe. The surrounding framer supplies the frame number (0 to 15) alongside each timeslot-0 byte. The framer also keeps bytes at least eight clock cycles apart.

Top module: `sa_tx_inserter`

## Requirements
- R1: A byte accepted with an even frame number leaves unchanged on `ts0_data_o`, with `ts0_valid_o` high one cycle after `ts0_valid_i`.
- R2: In register mode, each selected position of a byte with an odd frame number f takes bit f>>1 of its position register. Sa4..Sa8 sit at data bits 4..0; bit 7 is the first bit on the line. The output appears one cycle after the input.
- R3: Data bits 7 to 5, and every position whose mask bit is clear, are copied from input to output.
- R4: Register writes land in a shadow copy. They take effect only when a byte with frame number 0 is accepted. Bytes before that use the previous settings.
- R5: Write address map:
  - addresses 0 to 4 write the Sa4 to Sa8 registers, 8 bits each;
  - address 5 writes the mask from data bits 4..0 (bit 0 = Sa4);
  - address 6 bit 0 selects serial mode (1) or register mode (0);
  - address 7 has no effect.
- R6: In serial mode, a byte with an odd frame number drives one `ser_req_o` pulse per selected position, in order Sa4 to Sa8. `ser_bit_i` is sampled in the same cycle as its request and lands in that position. The output appears six cycles after the input.
- R7: `ser_req_o` stays low in register mode and for even frames. In serial mode an even frame still leaves after one cycle.
- R8: After reset the outputs are low, and all registers, the mask and the mode are zero.
- R9: `ts0_valid_o` is a single-cycle pulse per accepted byte. A `ts0_valid_i` arriving while a serial fill is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_idx_i | input | 4 | Frame number within the multiframe, valid with ts0_valid_i |
| ts0_valid_i | input | 1 | Timeslot-0 byte present |
| ts0_data_i | input | 8 | Timeslot-0 byte, bit 7 sent first |
| ts0_valid_o | output | 1 | Processed byte present |
| ts0_data_o | output | 8 | Processed timeslot-0 byte |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| ser_req_o | output | 1 | Request for one serial spare bit |
| ser_bit_i | input | 1 | Serial spare bit, valid while ser_req_o is high |

## Verification
The hardest situation to reach is a configuration change that is pending but not yet applied. New mask, mode or register values sit in the shadow copy while bytes of the old multiframe are still being processed. The stimulus reaches it by writing mid-multiframe and then sending odd frames before frame 0. It repeats this for a register value, for the mask and for the switch into serial mode. The old behaviour must be seen first, and the new behaviour only after frame 0. A second hard case is a new byte that arrives during a serial fill. The bench pulses `ts0_valid_i` one cycle after starting a fill and expects exactly one output pulse.

// File: rtl/sa_tx_pkg.sv
package sa_tx_pkg;
  localparam int unsigned TS_W         = 8;
  localparam int unsigned SA_FIRST_IDX = 4;  // data bit carrying Sa4

  function automatic logic [2:0] sa_bit_idx(input int unsigned k);
    return 3'(SA_FIRST_IDX - k);
  endfunction
endpackage

// File: rtl/sa_cfg_bank.sv
module sa_cfg_bank #(
  parameter int unsigned SA_NUM  = 5,
  parameter int unsigned NAF_NUM = 8,
  parameter int unsigned AW      = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [AW-1:0]                    wr_addr_i,
  input  logic [NAF_NUM-1:0]               wr_data_i,
  input  logic                             load_i,
  output logic [SA_NUM-1:0][NAF_NUM-1:0]   act_sa_o,
  output logic [SA_NUM-1:0]                act_mask_o,
  output logic                             act_serial_o
);
  localparam logic [AW-1:0] ADDR_MASK = AW'(SA_NUM);
  localparam logic [AW-1:0] ADDR_MODE = AW'(SA_NUM + 1);

  logic [SA_NUM-1:0][NAF_NUM-1:0] shd_sa;
  logic [SA_NUM-1:0]              shd_mask;
  logic                           shd_serial;

  for (genvar k = 0; k < SA_NUM; k++) begin : g_pos
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_sa[k]   <= '0;
        act_sa_o[k] <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == AW'(k)) shd_sa[k] <= wr_data_i;
        if (load_i) act_sa_o[k] <= shd_sa[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_mask     <= '0;
      shd_serial   <= 1'b0;
      act_mask_o   <= '0;
      act_serial_o <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == ADDR_MASK) shd_mask <= wr_data_i[SA_NUM-1:0];
      if (wr_en_i && wr_addr_i == ADDR_MODE) shd_serial <= wr_data_i[0];
      if (load_i) begin
        act_mask_o   <= shd_mask;
        act_serial_o <= shd_serial;
      end
    end
  end
endmodule

// File: rtl/sa_frame_pick.sv
module sa_frame_pick #(
  parameter int unsigned SA_NUM  = 5,
  parameter int unsigned NAF_NUM = 8,
  localparam int unsigned NW     = $clog2(NAF_NUM)
) (
  input  logic [SA_NUM-1:0][NAF_NUM-1:0] act_sa_i,
  input  logic [NW-1:0]                  naf_idx_i,
  output logic [SA_NUM-1:0]              pick_o
);
  for (genvar k = 0; k < SA_NUM; k++) begin : g_pick
    assign pick_o[k] = act_sa_i[k][naf_idx_i];
  end
endmodule

// File: rtl/sa_serial_walk.sv
module sa_serial_walk #(
  parameter int unsigned SA_NUM = 5,
  localparam int unsigned SW    = $clog2(SA_NUM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SA_NUM-1:0] mask_i,
  output logic              busy_o,
  output logic              ser_req_o,
  output logic [SW-1:0]     step_o,
  output logic              done_o
);
  typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;
  walk_st_e st_q;
  logic [SW-1:0]     cnt_q;
  logic [SA_NUM-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_WALK;
          cnt_q  <= '0;
          mask_q <= mask_i;
        end
        default: begin
          if (cnt_q == SW'(SA_NUM - 1)) st_q <= ST_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign busy_o    = (st_q == ST_WALK);
  assign step_o    = cnt_q;
  assign ser_req_o = busy_o && mask_q[cnt_q];
  assign done_o    = busy_o && (cnt_q == SW'(SA_NUM - 1));
endmodule

// File: rtl/sa_tx_inserter.sv
module sa_tx_inserter
  import sa_tx_pkg::*;
#(
  parameter int unsigned SA_NUM = 5,
  parameter int unsigned FRAMES = 16,
  parameter int unsigned AW     = 3,
  localparam int unsigned NAF_NUM = FRAMES / 2,
  localparam int unsigned FW      = $clog2(FRAMES),
  localparam int unsigned NW      = $clog2(NAF_NUM),
  localparam int unsigned SW      = $clog2(SA_NUM)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FW-1:0]   frame_idx_i,
  input  logic            ts0_valid_i,
  input  logic [TS_W-1:0] ts0_data_i,
  output logic            ts0_valid_o,
  output logic [TS_W-1:0] ts0_data_o,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [NAF_NUM-1:0] wr_data_i,
  output logic            ser_req_o,
  input  logic            ser_bit_i
);
  logic [SA_NUM-1:0][NAF_NUM-1:0] act_sa;
  logic [SA_NUM-1:0] act_mask, pick;
  logic              act_serial;
  logic              busy, done, accept, is_naf, start, load;
  logic [SW-1:0]     step;
  logic [TS_W-1:0]   hold_q, hold_nxt, merged;

  assign accept = ts0_valid_i && !busy;
  assign is_naf = frame_idx_i[0];
  assign load   = accept && (frame_idx_i == '0);
  assign start  = accept && is_naf && act_serial;

  sa_cfg_bank #(.SA_NUM(SA_NUM), .NAF_NUM(NAF_NUM), .AW(AW)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(load), .act_sa_o(act_sa), .act_mask_o(act_mask),
    .act_serial_o(act_serial)
  );

  sa_frame_pick #(.SA_NUM(SA_NUM), .NAF_NUM(NAF_NUM)) u_pick (
    .act_sa_i(act_sa), .naf_idx_i(frame_idx_i[FW-1:1]), .pick_o(pick)
  );

  sa_serial_walk #(.SA_NUM(SA_NUM)) u_walk (
    .clk_i, .rst_ni, .start_i(start), .mask_i(act_mask),
    .busy_o(busy), .ser_req_o(ser_req_o), .step_o(step), .done_o(done)
  );

  always_comb begin
    merged = ts0_data_i;
    if (is_naf && !act_serial) begin
      for (int unsigned k = 0; k < SA_NUM; k++)
        if (act_mask[k]) merged[sa_bit_idx(k)] = pick[k];
    end
  end

  always_comb begin
    hold_nxt = hold_q;
    if (ser_req_o) hold_nxt[sa_bit_idx(32'(step))] = ser_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      ts0_data_o  <= '0;
      ts0_valid_o <= 1'b0;
    end else begin
      ts0_valid_o <= 1'b0;
      if (start) begin
        hold_q <= ts0_data_i;
      end else if (accept) begin
        ts0_data_o  <= merged;
        ts0_valid_o <= 1'b1;
      end else if (busy) begin
        hold_q <= hold_nxt;
        if (done) begin
          ts0_data_o  <= hold_nxt;
          ts0_valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sa_tx_inserter_chk.sv
module sa_tx_inserter_chk #(
  parameter int unsigned SA_NUM = 5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ts0_valid_i,
  input logic       frame_lsb_i,
  input logic [7:0] ts0_data_i,
  input logic       ts0_valid_o,
  input logic [7:0] ts0_data_o,
  input logic       ser_req_o,
  input logic       busy_i,
  input logic       serial_i
);
  logic [3:0] req_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_cnt <= '0;
    else if (ts0_valid_i && !busy_i) req_cnt <= '0;
    else if (ser_req_o) req_cnt <= req_cnt + 1'b1;
  end

  a_r1_even_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts0_valid_i && !busy_i && !frame_lsb_i |=> ts0_valid_o && ts0_data_o == $past(ts0_data_i));

  a_r3_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts0_valid_i && !busy_i && !serial_i |=> ts0_data_o[7:5] == $past(ts0_data_i[7:5]));

  a_r7_req_serial_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_req_o |-> busy_i && serial_i);

  a_r6_req_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_req_o |-> req_cnt < 4'(SA_NUM));

  a_r9_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts0_valid_o |=> !ts0_valid_o);
endmodule

bind sa_tx_inserter sa_tx_inserter_chk #(.SA_NUM(SA_NUM)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ts0_valid_i(ts0_valid_i),
  .frame_lsb_i(frame_idx_i[0]), .ts0_data_i(ts0_data_i),
  .ts0_valid_o(ts0_valid_o), .ts0_data_o(ts0_data_o),
  .ser_req_o(ser_req_o), .busy_i(busy), .serial_i(act_serial)
);

// File: tb/tb_sa_tx_inserter.sv
`timescale 1ns/1ps
module tb_sa_tx_inserter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] frame = '0;
  logic       vin = 1'b0, vout, wr_en = 1'b0, req, sbit;
  logic [7:0] din = '0, dout, wdata = '0;
  logic [2:0] waddr = '0;

  always #4 clk = ~clk;

  sa_tx_inserter dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_idx_i(frame), .ts0_valid_i(vin),
    .ts0_data_i(din), .ts0_valid_o(vout), .ts0_data_o(dout),
    .wr_en_i(wr_en), .wr_addr_i(waddr), .wr_data_i(wdata),
    .ser_req_o(req), .ser_bit_i(sbit)
  );

  localparam logic [31:0] PAT = 32'hB2E1_5C93;
  int sidx = 0, reqs = 0;
  assign sbit = PAT[sidx % 32];
  always @(posedge clk) if (req) begin sidx <= sidx + 1; reqs <= reqs + 1; end

  int checks = 0, fails = 0;
  logic [7:0] shd_sa [5], act_sa [5];
  logic [4:0] shd_mask = '0, act_mask = '0;
  logic       shd_ser = 1'b0, act_ser = 1'b0;

  localparam logic [7:0] DIN_TAB [16] = '{8'h1B, 8'hE0, 8'h9B, 8'h7F, 8'h1B, 8'h00,
    8'h9B, 8'hAA, 8'h1B, 8'h55, 8'h9B, 8'hC3, 8'h1B, 8'h3C, 8'h9B, 8'hFF};

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_s, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; waddr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    if (a < 3'd5) shd_sa[a] = d;
    else if (a == 3'd5) shd_mask = d[4:0];
    else if (a == 3'd6) shd_ser = d[0];
  endtask

  function automatic logic [7:0] model_reg(input logic [3:0] f, input logic [7:0] d);
    logic [7:0] r = d;
    if (f[0] && !act_ser)
      for (int k = 0; k < 5; k++) if (act_mask[k]) r[4-k] = act_sa[k][f[3:1]];
    return r;
  endfunction

  task automatic send(input logic [3:0] f, input logic [7:0] d,
                      output logic [7:0] q, output int lat, output int nreq);
    int r0;
    r0 = reqs;
    @(negedge clk); frame = f; din = d; vin = 1'b1;
    if (f == 4'd0) begin
      act_sa = shd_sa; act_mask = shd_mask; act_ser = shd_ser;
    end
    lat = 0; q = 'x;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk); vin = 1'b0;
      if (vout) begin lat = i; q = dout; break; end
    end
    repeat (2) @(negedge clk);
    nreq = reqs - r0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q, e;
    int lat, nr, s0;
    for (int k = 0; k < 5; k++) begin shd_sa[k] = '0; act_sa[k] = '0; end
    repeat (3) @(negedge clk);
    chk("R8 valid_o in reset", 32'(vout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 valid_o after reset", 32'(vout), 0);
    chk("R8 ser_req after reset", 32'(req), 0);
    send(4'd3, 8'h5A, q, lat, nr);
    chk("R8 zero config passes odd frame", 32'(q), 32'h5A);

    // register mode setup
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'hFF); wr(3'd3, 8'h00); wr(3'd4, 8'h96);
    wr(3'd5, 8'h15);
    send(4'd5, 8'h00, q, lat, nr);
    chk("R4 pending config not applied", 32'(q), 32'h00);

    // table walk over one multiframe
    for (int i = 0; i < 16; i++) begin
      e = model_reg(4'(i), DIN_TAB[i]);
      send(4'(i), DIN_TAB[i], q, lat, nr);
      if (i[0]) begin
        chk("R2 register insert data", 32'(q), 32'(e));
        chk("R2 register latency", 32'(lat), 1);
      end else begin
        chk("R1 even frame data", 32'(q), 32'(DIN_TAB[i]));
        chk("R1 even frame latency", 32'(lat), 1);
      end
      chk("R3 upper bits kept", 32'(q[7:5]), 32'(DIN_TAB[i][7:5]));
      chk("R7 no req in register mode", 32'(nr), 0);
    end

    // mid-multiframe write: old value until frame 0
    wr(3'd0, 8'h0F);
    e = model_reg(4'd1, 8'h00);
    send(4'd1, 8'h00, q, lat, nr);
    chk("R4 old Sa4 before boundary", 32'(q), 32'(e));
    send(4'd0, 8'h00, q, lat, nr);
    e = model_reg(4'd1, 8'h00);
    send(4'd1, 8'h00, q, lat, nr);
    chk("R4 new Sa4 after boundary", 32'(q), 32'(e));
    chk("R2 new Sa4 bit", 32'(q[4]), 32'(1));

    // unmapped address
    wr(3'd7, 8'hFF);
    send(4'd0, 8'hE7, q, lat, nr);
    e = model_reg(4'd9, 8'hE7);
    send(4'd9, 8'hE7, q, lat, nr);
    chk("R5 address 7 ignored", 32'(q), 32'(e));

    // serial mode: pending until boundary
    wr(3'd5, 8'h0B); wr(3'd6, 8'h01);
    e = model_reg(4'd3, 8'h44);
    send(4'd3, 8'h44, q, lat, nr);
    chk("R4 serial pending: data", 32'(q), 32'(e));
    chk("R4 serial pending: no req", 32'(nr), 0);
    send(4'd0, 8'h81, q, lat, nr);
    chk("R7 even frame serial latency", 32'(lat), 1);
    chk("R7 even frame serial no req", 32'(nr), 0);
    chk("R7 even frame serial data", 32'(q), 32'h81);
    for (int f = 1; f < 16; f += 2) begin
      s0 = sidx;
      e = DIN_TAB[f];
      e[4] = PAT[s0 % 32]; e[3] = PAT[(s0 + 1) % 32]; e[1] = PAT[(s0 + 2) % 32];
      send(4'(f), DIN_TAB[f], q, lat, nr);
      chk("R6 serial data order", 32'(q), 32'(e));
      chk("R6 serial latency", 32'(lat), 6);
      chk("R6 serial req count", 32'(nr), 3);
    end
    send(4'd2, 8'h3E, q, lat, nr);
    chk("R7 serial even no req", 32'(nr), 0);

    // new byte during fill is dropped
    begin
      int pulses = 0;
      @(negedge clk); frame = 4'd5; din = 8'h00; vin = 1'b1;
      @(negedge clk); frame = 4'd0; din = 8'hFF;
      @(negedge clk); vin = 1'b0;
      for (int i = 0; i < 12; i++) begin
        if (vout) pulses++;
        @(negedge clk);
      end
      chk("R9 one output per accepted byte", 32'(pulses), 1);
    end
    s0 = sidx;
    e = 8'h00; e[4] = PAT[s0 % 32]; e[3] = PAT[(s0 + 1) % 32]; e[1] = PAT[(s0 + 2) % 32];
    send(4'd7, 8'h00, q, lat, nr);
    chk("R9 config kept after dropped byte", 32'(lat), 6);
    chk("R9 serial data after dropped byte", 32'(q), 32'(e));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule